// File: doc/BRIEF.md
# Machine-Mode CSR File with Trap Sequencing

This block holds the machine-level control and status registers of a small 32-bit in-order core. Each cycle the decoder hands it one command (idle, read, write, set or clear), a 12-bit register address and an operand. The operand is either the source register value or a zero-extended 5-bit immediate. The block returns the old contents of the addressed register and flags any access that the current privilege level or the register's kind does not allow.

The block also sequences traps. When the pipeline reports an exception, or when an enabled external interrupt is taken, it does four things. It saves the faulting PC and the cause, pushes the interrupt-enable and privilege bits into their saved copies, and raises the privilege to machine mode. It also presents the handler address to the fetch logic. A return-from-trap pops the saved bits back, and the saved PC is always available for that redirect.

The interrupt-pending flag is kept apart from the interrupt-taken flag, so a core parked on a wait-for-interrupt can wake up even while interrupts are globally disabled. A cycle counter and a retired-instruction counter are readable at user level. All pins are plain, level-sampled control and status signals with no handshake. A command is acted on in the cycle it is presented, and read data is combinational in that same cycle.

Top module: `csr_trap_unit`

## Requirements
- R1: Command codes are 0 idle, 1 read, 2 write, 3 set and 4 clear; codes 5 to 7 act as idle. An idle command changes no register and never raises the illegal-access flag.
- R2: Every non-idle command returns the register's value before the command. Write stores the operand, set stores old OR operand, and clear stores old AND NOT operand, all visible from the next cycle.
- R3: With imm_sel_i at 1 the operand is imm_i zero-extended; otherwise it is rs1_val_i.
- R4: The illegal-access flag rises in three cases: the address is not one of 0x300, 0x304, 0x305, 0x340, 0x341, 0x342, 0xC00, 0xC02, 0xC80 or 0xC82; a write, set or clear targets an address whose bits 11:10 are 11; or address bits 9:8 exceed the current privilege. An illegal command changes no register.
- R5: An exception or a taken interrupt copies trap_pc_i into the saved PC (0x341) and the cause into 0x342. It moves the global enable and privilege into their saved copies, clears the global enable and sets privilege to 3. The trap address register 0x305 drives handler_pc_o, and writes to it clear bits 1:0.
- R6: ecall_code_o equals 8 plus the current privilege level.
- R7: A return-from-trap at privilege 1 to 3 restores privilege and global enable from the saved copies, then sets the saved privilege to 0 and the saved enable to 1. At privilege 0 it raises the illegal-access flag and changes nothing. The status register 0x300 holds the global enable in bit 0, the current privilege in bits 2:1 (read-only), the saved enable in bit 3 and the saved privilege in bits 5:4.
- R8: irq_pending_o equals irq_i AND bit 0 of the enable register 0x304, regardless of the global enable.
- R9: irq_taken_o is high when an interrupt is pending, the global enable is set and no exception is reported. It lasts one cycle, and it records cause 0x8000000B.
- R10: Counter 0xC00/0xC80 (low/high half) counts every clock from 0 at reset. Counter 0xC02/0xC82 counts cycles with retire_i high.
- R11: An exception in the same cycle as a pending interrupt wins and records its own code. A trap in a cycle blocks that cycle's CSR write.
- R12: After reset the privilege is 3, the status register reads 0x6, the saved PC, cause and enable register read 0, and the trap address is RESET_TVEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | CSR command code |
| addr_i | input | 12 | CSR address |
| rs1_val_i | input | XLEN | Register operand |
| imm_i | input | 5 | Immediate operand |
| imm_sel_i | input | 1 | Selects the immediate operand |
| exc_valid_i | input | 1 | Exception reported this cycle |
| exc_code_i | input | 4 | Exception cause code |
| trap_pc_i | input | XLEN | PC saved on a trap |
| trap_ret_i | input | 1 | Return-from-trap request |
| irq_i | input | 1 | External interrupt level |
| retire_i | input | 1 | One instruction retires |
| rdata_o | output | XLEN | Old value of the addressed CSR |
| illegal_o | output | 1 | Illegal access or illegal return |
| irq_pending_o | output | 1 | Enabled interrupt is pending |
| irq_taken_o | output | 1 | Interrupt taken this cycle |
| handler_pc_o | output | XLEN | Trap handler address |
| epc_o | output | XLEN | Saved exception PC |
| prv_o | output | 2 | Current privilege level |
| ecall_code_o | output | 4 | Cause code for an environment call |

## Verification
The embedded assertions check four things on every cycle. An interrupt-taken pulse never lasts two cycles. Any trap leaves machine mode, with the enable cleared and the PC saved. An illegal or idle command leaves the scratch and trap-address registers untouched, and a refused return keeps the status. The counters step by exactly one or hold. The bench scenarios cover what needs a sequence to observe. These are the set/clear arithmetic and the returned old values, the immediate-versus-register operand, and the privilege round trip through return and trap. They also cover interrupt masking by the per-source and global enables, and exception-over-interrupt priority with write suppression.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_SET   = 3'd3,
    CMD_CLEAR = 3'd4
  } csr_cmd_e;

  localparam int CODE_W = 4;
  localparam int ADDR_W = 12;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_FETCH_ALIGN = 4'd0,
    CAUSE_BAD_INSN    = 4'd2,
    CAUSE_BREAK       = 4'd3,
    CAUSE_LOAD_ALIGN  = 4'd4,
    CAUSE_STORE_ALIGN = 4'd6,
    CAUSE_ECALL_BASE  = 4'd8,
    CAUSE_EXT_IRQ     = 4'd11
  } cause_code_e;

  localparam logic [1:0] LVL_USER    = 2'd0;
  localparam logic [1:0] LVL_MACHINE = 2'd3;

  localparam logic [ADDR_W-1:0] ADR_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] ADR_IRQEN   = 12'h304;
  localparam logic [ADDR_W-1:0] ADR_TVEC    = 12'h305;
  localparam logic [ADDR_W-1:0] ADR_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] ADR_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] ADR_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] ADR_CYC_LO  = 12'hC00;
  localparam logic [ADDR_W-1:0] ADR_RET_LO  = 12'hC02;
  localparam logic [ADDR_W-1:0] ADR_CYC_HI  = 12'hC80;
  localparam logic [ADDR_W-1:0] ADR_RET_HI  = 12'hC82;

  // ie is the least significant bit
  typedef struct packed {
    logic [1:0] prv_saved;
    logic       ie_saved;
    logic [1:0] prv;
    logic       ie;
  } mstat_t;

  function automatic logic csr_known(input logic [ADDR_W-1:0] a);
    return a inside {ADR_STATUS, ADR_IRQEN, ADR_TVEC, ADR_SCRATCH, ADR_EPC,
                     ADR_CAUSE, ADR_CYC_LO, ADR_RET_LO, ADR_CYC_HI, ADR_RET_HI};
  endfunction

endpackage

// File: rtl/csr_access_chk.sv
module csr_access_chk
  import csr_trap_pkg::*;
(
  input  csr_cmd_e          cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        prv,
  output logic              illegal,
  output logic              mod_ok
);
  logic active, modifies, read_only, under_priv, unknown;

  always_comb begin
    active     = cmd inside {CMD_READ, CMD_WRITE, CMD_SET, CMD_CLEAR};
    modifies   = cmd inside {CMD_WRITE, CMD_SET, CMD_CLEAR};
    read_only  = (addr[11:10] == 2'b11);
    under_priv = (addr[9:8] > prv);
    unknown    = !csr_known(addr);
    illegal    = active && (unknown || under_priv || (modifies && read_only));
    mod_ok     = modifies && !illegal;
  end
endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= count + W'(1);
  end

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> count == $past(count) + W'(1));
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
endmodule

// File: rtl/csr_trap_seq.sv
module csr_trap_seq
  import csr_trap_pkg::*;
#(
  parameter int             XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_TVEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              trap_ret,
  input  logic              irq_line,
  input  logic              wr_status,
  input  logic              wr_irqen,
  input  logic              wr_tvec,
  input  logic              wr_epc,
  input  logic              wr_cause,
  input  logic [XLEN-1:0]   wdata,
  output mstat_t            status,
  output logic              irq_en,
  output logic [XLEN-1:0]   tvec,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic              irq_pending,
  output logic              irq_taken,
  output logic              trap_any,
  output logic              ret_bad
);
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic ret_ok;
  logic [XLEN-1:0] cause_next;

  always_comb begin
    irq_pending = irq_line && irq_en;
    irq_taken   = irq_pending && status.ie && !exc_valid;
    trap_any    = exc_valid || irq_taken;
    ret_bad     = trap_ret && (status.prv == LVL_USER);
    ret_ok      = trap_ret && (status.prv != LVL_USER) && !trap_any;
    cause_next  = exc_valid ? {1'b0, {PAD_W{1'b0}}, exc_code}
                            : {1'b1, {PAD_W{1'b0}}, CODE_W'(CAUSE_EXT_IRQ)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '{prv_saved: LVL_USER, ie_saved: 1'b0, prv: LVL_MACHINE, ie: 1'b0};
      epc    <= '0;
      cause  <= '0;
    end else if (trap_any) begin
      epc              <= trap_pc;
      cause            <= cause_next;
      status.prv_saved <= status.prv;
      status.ie_saved  <= status.ie;
      status.prv       <= LVL_MACHINE;
      status.ie        <= 1'b0;
    end else if (ret_ok) begin
      status.prv       <= status.prv_saved;
      status.ie        <= status.ie_saved;
      status.prv_saved <= LVL_USER;
      status.ie_saved  <= 1'b1;
    end else begin
      if (wr_status) begin
        status.ie        <= wdata[0];
        status.ie_saved  <= wdata[3];
        status.prv_saved <= wdata[5:4];
      end
      if (wr_epc)   epc   <= wdata;
      if (wr_cause) cause <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvec   <= RESET_TVEC;
      irq_en <= 1'b0;
    end else begin
      if (wr_tvec)  tvec   <= {wdata[XLEN-1:2], 2'b00};
      if (wr_irqen) irq_en <= wdata[0];
    end
  end

  // R9
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> !irq_taken);
  // R5
  trap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_any |=> (status.prv == LVL_MACHINE) && !status.ie);
  // R5
  trap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_any |=> epc == $past(trap_pc));
  // R7
  bad_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_bad && !trap_any) |=> $stable(status));
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              IMM_W      = 5,
  parameter logic [XLEN-1:0] RESET_TVEC = XLEN'(256)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [11:0]       addr_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  input  logic              exc_valid_i,
  input  logic [3:0]        exc_code_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic              trap_ret_i,
  input  logic              irq_i,
  input  logic              retire_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              illegal_o,
  output logic              irq_pending_o,
  output logic              irq_taken_o,
  output logic [XLEN-1:0]   handler_pc_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [1:0]        prv_o,
  output logic [3:0]        ecall_code_o
);
  localparam int CNT_W  = 2 * XLEN;
  localparam int N_CNT  = 2;
  localparam int STAT_W = $bits(mstat_t);

  csr_cmd_e        cmd;
  logic            acc_illegal, mod_ok, wr_ok;
  logic [XLEN-1:0] operand, old_val, new_val, scratch_q;
  mstat_t          status;
  logic            irq_en, trap_any, ret_bad;
  logic [XLEN-1:0] tvec, epc, cause;
  logic [N_CNT-1:0] cnt_en;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  assign cmd = csr_cmd_e'(cmd_i);

  csr_access_chk u_acc (
    .cmd     (cmd),
    .addr    (addr_i),
    .prv     (status.prv),
    .illegal (acc_illegal),
    .mod_ok  (mod_ok)
  );

  // R3 operand select
  assign operand = imm_sel_i ? {{(XLEN-IMM_W){1'b0}}, imm_i} : rs1_val_i;

  always_comb begin
    case (addr_i)
      ADR_STATUS:  old_val = {{(XLEN-STAT_W){1'b0}}, status};
      ADR_IRQEN:   old_val = {{(XLEN-1){1'b0}}, irq_en};
      ADR_TVEC:    old_val = tvec;
      ADR_SCRATCH: old_val = scratch_q;
      ADR_EPC:     old_val = epc;
      ADR_CAUSE:   old_val = cause;
      ADR_CYC_LO:  old_val = cnt_val[0][XLEN-1:0];
      ADR_CYC_HI:  old_val = cnt_val[0][CNT_W-1:XLEN];
      ADR_RET_LO:  old_val = cnt_val[1][XLEN-1:0];
      ADR_RET_HI:  old_val = cnt_val[1][CNT_W-1:XLEN];
      default:     old_val = '0;
    endcase
  end

  // R2 read-modify-write
  always_comb begin
    case (cmd)
      CMD_SET:   new_val = old_val | operand;
      CMD_CLEAR: new_val = old_val & ~operand;
      default:   new_val = operand;
    endcase
  end

  // R11 a trap blocks the CSR write of its cycle
  assign wr_ok = mod_ok && !trap_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scratch_q <= '0;
    else if (wr_ok && addr_i == ADR_SCRATCH) scratch_q <= new_val;
  end

  csr_trap_seq #(.XLEN(XLEN), .RESET_TVEC(RESET_TVEC)) u_trap (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid_i),
    .exc_code    (exc_code_i),
    .trap_pc     (trap_pc_i),
    .trap_ret    (trap_ret_i),
    .irq_line    (irq_i),
    .wr_status   (wr_ok && addr_i == ADR_STATUS),
    .wr_irqen    (wr_ok && addr_i == ADR_IRQEN),
    .wr_tvec     (wr_ok && addr_i == ADR_TVEC),
    .wr_epc      (wr_ok && addr_i == ADR_EPC),
    .wr_cause    (wr_ok && addr_i == ADR_CAUSE),
    .wdata       (new_val),
    .status      (status),
    .irq_en      (irq_en),
    .tvec        (tvec),
    .epc         (epc),
    .cause       (cause),
    .irq_pending (irq_pending_o),
    .irq_taken   (irq_taken_o),
    .trap_any    (trap_any),
    .ret_bad     (ret_bad)
  );

  // R10 counter 0 runs every clock, counter 1 on retire
  assign cnt_en = {retire_i, 1'b1};

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    csr_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cnt_en[gi]),
      .count (cnt_val[gi])
    );
  end

  assign rdata_o      = old_val;
  assign illegal_o    = acc_illegal || ret_bad;
  assign handler_pc_o = tvec;
  assign epc_o        = epc;
  assign prv_o        = status.prv;
  // R6
  assign ecall_code_o = CODE_W'(CAUSE_ECALL_BASE) + {2'b00, status.prv};

  // R4
  ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_illegal && !trap_any) |=> $stable(scratch_q) && $stable(tvec));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0) |=> $stable(scratch_q) && $stable(tvec));
  // R1
  idle_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0 && !trap_ret_i) |-> !illegal_o);
endmodule

// File: tb/sim_csr_trap_unit.sv
module sim_csr_trap_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [11:0] addr_i = '0;
  logic [XLEN-1:0] rs1_val_i = '0;
  logic [4:0] imm_i = '0;
  logic imm_sel_i = 1'b0, exc_valid_i = 1'b0, trap_ret_i = 1'b0;
  logic irq_i = 1'b0, retire_i = 1'b0;
  logic [3:0] exc_code_i = '0;
  logic [XLEN-1:0] trap_pc_i = '0;
  logic [XLEN-1:0] rdata_o, handler_pc_o, epc_o;
  logic illegal_o, irq_pending_o, irq_taken_o;
  logic [1:0] prv_o;
  logic [3:0] ecall_code_o;

  always #10 clk = ~clk;

  csr_trap_unit u0 (.*);

  typedef struct {int kind; logic [31:0] exp; int req;} item_t;
  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] c0, c1;

  localparam int K_RD = 0, K_ILL = 1, K_PEND = 2, K_TAKE = 3, K_HND = 4, K_EPC = 5, K_PRV = 6, K_ECL = 7;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input logic [31:0] v, input int req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = rdata_o;
        K_ILL:   act = {31'd0, illegal_o};
        K_PEND:  act = {31'd0, irq_pending_o};
        K_TAKE:  act = {31'd0, irq_taken_o};
        K_HND:   act = handler_pc_o;
        K_EPC:   act = epc_o;
        K_PRV:   act = {30'd0, prv_o};
        default: act = {28'd0, ecall_code_o};
      endcase
      check(it.req, act, it.exp);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cmd_i = '0; addr_i = '0; rs1_val_i = '0; imm_i = '0; imm_sel_i = 1'b0;
    exc_valid_i = 1'b0; exc_code_i = '0; trap_pc_i = '0; trap_ret_i = 1'b0; retire_i = 1'b0;
  endtask

  task automatic csr(input logic [2:0] c, input logic [11:0] a, input logic [31:0] v,
                     input logic do_rd, input logic [31:0] exp_rd, input logic exp_ill, input int req);
    step();
    cmd_i = c; addr_i = a; rs1_val_i = v;
    if (do_rd) expect_item(K_RD, exp_rd, req);
    expect_item(K_ILL, {31'd0, exp_ill}, req);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    step();
    expect_item(K_PRV, 32'd3, 12); expect_item(K_HND, 32'h100, 12);
    expect_item(K_EPC, 32'h0, 12); expect_item(K_PEND, 0, 12); expect_item(K_TAKE, 0, 12);
    expect_item(K_ECL, 32'd11, 6);  // R6 at machine level
    csr(3'd1, 12'h300, 0, 1, 32'h6, 0, 12);
    csr(3'd1, 12'h342, 0, 1, 32'h0, 0, 12);
    csr(3'd1, 12'h304, 0, 1, 32'h0, 0, 12);
    // R2 write / set / clear with old value returned
    csr(3'd2, 12'h340, 32'hA5A5_0000, 1, 32'h0, 0, 2);
    csr(3'd3, 12'h340, 32'h0000_00FF, 1, 32'hA5A5_0000, 0, 2);
    csr(3'd4, 12'h340, 32'hA500_000F, 1, 32'hA5A5_00FF, 0, 2);
    csr(3'd1, 12'h340, 0, 1, 32'h00A5_00F0, 0, 2);
    // R3 immediate operand
    csr(3'd2, 12'h340, 32'hFFFF_FFFF, 0, 0, 0, 3);
    imm_i = 5'h1F; imm_sel_i = 1'b1;
    csr(3'd1, 12'h340, 0, 1, 32'h0000_001F, 0, 3);
    // R1 idle and undefined codes leave state alone
    csr(3'd0, 12'h340, 32'hDEAD_BEEF, 0, 0, 0, 1);
    csr(3'd6, 12'h340, 32'hDEAD_BEEF, 0, 0, 0, 1);
    csr(3'd1, 12'h340, 0, 1, 32'h1F, 0, 1);
    // R4 read-only and unknown addresses
    csr(3'd2, 12'hC00, 32'h5, 0, 0, 1, 4);
    csr(3'd1, 12'hC82, 0, 0, 0, 0, 4);
    csr(3'd1, 12'h7FF, 0, 0, 0, 1, 4);
    csr(3'd3, 12'h123, 1, 0, 0, 1, 4);
    // R10 retire counter and cycle counter
    csr(3'd1, 12'hC02, 0, 1, 32'd0, 0, 10);
    for (int i = 0; i < 3; i++) begin step(); retire_i = 1'b1; end
    csr(3'd1, 12'hC02, 0, 1, 32'd3, 0, 10);
    step(); cmd_i = 3'd1; addr_i = 12'hC00; #5 c0 = rdata_o;
    repeat (5) step();
    step(); cmd_i = 3'd1; addr_i = 12'hC00; #5 c1 = rdata_o;
    check(10, c1 - c0, 32'd6);  // R10
    // R7 return to user level
    csr(3'd2, 12'h300, 32'h8, 1, 32'h6, 0, 7);
    csr(3'd1, 12'h300, 0, 1, 32'hE, 0, 7);
    step(); trap_ret_i = 1'b1; expect_item(K_ILL, 0, 7);
    step(); expect_item(K_PRV, 0, 7); expect_item(K_ECL, 32'd8, 6);  // R6 at user level
    csr(3'd1, 12'h300, 0, 0, 0, 1, 4);          // R4 privilege too low
    csr(3'd2, 12'h340, 32'h77, 0, 0, 1, 4);
    csr(3'd1, 12'hC00, 0, 0, 0, 0, 4);
    step(); trap_ret_i = 1'b1; expect_item(K_ILL, 1, 7);  // R7 return refused
    step(); expect_item(K_PRV, 0, 7);
    // R5 exception entry
    step(); exc_valid_i = 1'b1; exc_code_i = 4'd2; trap_pc_i = 32'h1234;
    expect_item(K_HND, 32'h100, 5);
    step(); expect_item(K_PRV, 3, 5); expect_item(K_EPC, 32'h1234, 5);
    csr(3'd1, 12'h342, 0, 1, 32'd2, 0, 5);
    csr(3'd1, 12'h300, 0, 1, 32'hE, 0, 5);
    csr(3'd1, 12'h340, 0, 1, 32'h1F, 0, 4);     // R4 refused write had no effect
    // R11 trap blocks same-cycle write
    csr(3'd2, 12'h340, 32'h55, 0, 0, 0, 11);
    exc_valid_i = 1'b1; exc_code_i = 4'd6; trap_pc_i = 32'h2000;
    csr(3'd1, 12'h340, 0, 1, 32'h1F, 0, 11);
    csr(3'd1, 12'h342, 0, 1, 32'd6, 0, 11);
    csr(3'd1, 12'h300, 0, 1, 32'h36, 0, 5);
    // R5 trap address register
    csr(3'd2, 12'h305, 32'h203, 1, 32'h100, 0, 5);
    step(); expect_item(K_HND, 32'h200, 5);
    // R8 / R9 interrupt path
    csr(3'd2, 12'h304, 32'h1, 0, 0, 0, 8);
    step(); irq_i = 1'b1; expect_item(K_PEND, 1, 8); expect_item(K_TAKE, 0, 9);
    csr(3'd2, 12'h300, 32'h1, 0, 0, 0, 9); expect_item(K_TAKE, 0, 9);
    step(); trap_pc_i = 32'h4444; expect_item(K_TAKE, 1, 9); expect_item(K_HND, 32'h200, 9);
    step(); expect_item(K_TAKE, 0, 9); expect_item(K_PEND, 1, 8); expect_item(K_EPC, 32'h4444, 9);
    csr(3'd1, 12'h342, 0, 1, 32'h8000_000B, 0, 9);
    // R11 exception beats interrupt
    csr(3'd2, 12'h300, 32'h1, 0, 0, 0, 11);
    step(); exc_valid_i = 1'b1; exc_code_i = 4'd3; trap_pc_i = 32'h88;
    expect_item(K_TAKE, 0, 11);
    csr(3'd1, 12'h342, 0, 1, 32'd3, 0, 11);
    irq_i = 1'b0;
    step(); expect_item(K_PEND, 0, 8);
    step();
    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule